// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reason a device may need to restart into one internal reset. It also drives the board-level reset line, which is a shared, active-low, open-drain wire. The reasons are: a restart request from the watchdog, a software write to the system control word that asks for a restart, a bus access that lands in a forbidden address window, another agent pulling the shared reset line low, and the power-on input.

Each reset event pulls the shared line low for a fixed minimum number of clocks, so that parts elsewhere on the board see a clean pulse. The internal reset then lasts a few clocks more, until the synchronised line level can be checked again. If something outside keeps the line low, the internal reset carries on without a break until the line is released. The block senses the line only while it is not pulling the line itself, so it can never hold itself in reset. A sticky cause word records what started the most recent reset. Only power-on clears that word.

Top module: `rstc_ctrl`

## Requirements
- R1: `wdog_req_i` high at a rising edge pulls `sys_rst_n_o` low after that edge. This also holds while a reset is already running, and the request then restarts the stretch.
- R2: A write on `ctl_wr_i` while `sys_rst_n_o` is high starts a reset if `ctl_wdata_i[14]` is 0 or `ctl_wdata_i[15]` is 1. Any other write stores its data in `ctl_q_o` and starts no reset.
- R3: `ctl_q_o` is 16'h4000 after power-on and is forced back to 16'h4000 during every reset. Writes made while `sys_rst_n_o` is low have no effect.
- R4: `bus_vld_i` high with `bus_addr_i` inside [R0_LO, R0_HI] or [R1_LO, R1_HI] (inclusive) starts a reset. Other addresses, and any address with `bus_vld_i` low, do not.
- R5: `rst_pin_i` low at a single rising edge is enough to start a reset. The reset begins at the third rising edge from that one (two synchroniser stages plus the load).
- R6: An event that loads at a rising edge asserts `rst_pin_oe_o` for PIN_STRETCH clocks (8) and keeps `sys_rst_n_o` low for PIN_STRETCH+SYNC_STAGES+1 clocks (11). A new event during that time restarts the count.
- R7: While `rst_pin_i` is held low by an outside agent, `sys_rst_n_o` stays low with no gap. The block's own drive of the line never extends the reset.
- R8: `por_n` low at once forces `sys_rst_n_o` low, `rst_pin_oe_o` high and `cause_o` to 0. After `por_n` rises, `rst_pin_oe_o` falls at the 8th rising edge and `sys_rst_n_o` rises at the 11th.
- R9: `cause_o` has bit 0 = watchdog, bit 1 = software, bit 2 = illegal address and bit 3 = line. It loads the set of causes present at the edge where a reset starts from idle. Restarts during a running reset leave it unchanged.
- R10: Illegal-window accesses and restart writes made while `sys_rst_n_o` is low neither extend the reset nor change `cause_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_pin_i | input | 1 | Sensed level of the shared reset line |
| wdog_req_i | input | 1 | Watchdog restart request |
| ctl_wr_i | input | 1 | Write strobe for the system control word |
| ctl_wdata_i | input | 16 | Write data for the system control word |
| bus_vld_i | input | 1 | Bus access valid |
| bus_addr_i | input | ADDR_W | Bus access address |
| sys_rst_n_o | output | 1 | Internal device reset, active low |
| rst_pin_oe_o | output | 1 | High to pull the shared reset line low |
| ctl_q_o | output | 16 | Current system control word |
| cause_o | output | 4 | Sticky cause of the last reset |

## Verification
The assertions assume that the shared line reads low whenever `rst_pin_oe_o` is high, as a real open-drain wire does. They also assume that the watchdog, write and bus inputs are valid at every sampled edge once `por_n` has been high for one clock. The bench meets both by modelling the line as the AND of its own driver and the block's pull-down. It changes every input only on falling clock edges and releases power-on between edges, so each request sits stable around the edge that samples it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int CTL_W       = 16;
  localparam logic [CTL_W-1:0] CTL_RST_VAL = 16'h4000;
  localparam int CTL_KEEP_B  = 14;  // must read 1 or a restart follows
  localparam int CTL_FIRE_B  = 15;  // a 1 here requests a restart
  localparam int NUM_CAUSE   = 4;
  localparam int CZ_WD       = 0;
  localparam int CZ_SW       = 1;
  localparam int CZ_ILL      = 2;
  localparam int CZ_PIN      = 3;
  typedef logic [NUM_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sq, sd;

  always_comb sd = {sq[STAGES-2:0], d};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sq <= '1;
    else        sq <= sd;
  end

  assign q = sq[STAGES-1];
endmodule

// File: rtl/rstc_range_chk.sv
module rstc_range_chk #(
  parameter int          ADDR_W = 16,
  parameter int unsigned R0_LO  = 32'h0100,
  parameter int unsigned R0_HI  = 32'h01FF,
  parameter int unsigned R1_LO  = 32'h7800,
  parameter int unsigned R1_HI  = 32'h7FFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int NR = 2;
  localparam logic [ADDR_W-1:0] LO_A [NR] = '{ADDR_W'(R0_LO), ADDR_W'(R1_LO)};
  localparam logic [ADDR_W-1:0] HI_A [NR] = '{ADDR_W'(R0_HI), ADDR_W'(R1_HI)};

  logic [NR-1:0] hit_v;

  for (genvar g = 0; g < NR; g++) begin : g_win
    assign hit_v[g] = (addr >= LO_A[g]) && (addr <= HI_A[g]);
  end

  assign hit = |hit_v;
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int STRETCH = 8,
  parameter int TAIL    = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic drive_o,
  output logic hold_o
);
  localparam int LOAD  = STRETCH + TAIL;
  localparam int CNT_W = $clog2(LOAD + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);
  localparam logic [CNT_W-1:0] TAIL_V = CNT_W'(TAIL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             drive_q, drive_d, hold_q, hold_d;

  always_comb begin
    cnt_en  = fire || (cnt_q != '0);
    cnt_d   = fire ? LOAD_V : (cnt_q - CNT_W'(1));
    if (!cnt_en) cnt_d = cnt_q;
    drive_d = cnt_d > TAIL_V;
    hold_d  = cnt_d != '0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q   <= LOAD_V;
      drive_q <= 1'b1;
      hold_q  <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      drive_q <= drive_d;
      hold_q  <= hold_d;
    end
  end

  assign drive_o = drive_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          PIN_STRETCH = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned R0_LO       = 32'h0100,
  parameter int unsigned R0_HI       = 32'h01FF,
  parameter int unsigned R1_LO       = 32'h7800,
  parameter int unsigned R1_HI       = 32'h7FFF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_i,
  input  logic              wdog_req_i,
  input  logic              ctl_wr_i,
  input  logic [15:0]       ctl_wdata_i,
  input  logic              bus_vld_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              sys_rst_n_o,
  output logic              rst_pin_oe_o,
  output logic [15:0]       ctl_q_o,
  output logic [3:0]        cause_o
);
  // One extra clock beyond the synchroniser lets the line be re-read
  // before the internal reset is let go.
  localparam int TAIL = SYNC_STAGES + 1;

  logic       drive, hold, pin_feed, pin_s, win_hit;
  logic       sw_evt, ill_evt, fire;
  cause_vec_t cz_now, cause_q, cause_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;

  // The line is only sensed while this block is not pulling it.
  assign pin_feed = rst_pin_i | drive;

  rstc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .d(pin_feed), .q(pin_s)
  );

  rstc_range_chk #(
    .ADDR_W(ADDR_W), .R0_LO(R0_LO), .R0_HI(R0_HI), .R1_LO(R1_LO), .R1_HI(R1_HI)
  ) u_win (
    .addr(bus_addr_i), .hit(win_hit)
  );

  always_comb begin
    sw_evt  = ctl_wr_i && !hold &&
              (!ctl_wdata_i[CTL_KEEP_B] || ctl_wdata_i[CTL_FIRE_B]);
    ill_evt = bus_vld_i && !hold && win_hit;
    cz_now          = '0;
    cz_now[CZ_WD]   = wdog_req_i;
    cz_now[CZ_SW]   = sw_evt;
    cz_now[CZ_ILL]  = ill_evt;
    cz_now[CZ_PIN]  = !pin_s;
    fire    = |cz_now;
    cause_d = (fire && !hold) ? cz_now : cause_q;
    if (hold || fire)  ctl_d = CTL_RST_VAL;
    else if (ctl_wr_i) ctl_d = ctl_wdata_i;
    else               ctl_d = ctl_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= '0;
      ctl_q   <= CTL_RST_VAL;
    end else begin
      cause_q <= cause_d;
      ctl_q   <= ctl_d;
    end
  end

  rstc_stretch #(.STRETCH(PIN_STRETCH), .TAIL(TAIL)) u_str (
    .clk(clk), .por_n(por_n), .fire(fire), .drive_o(drive), .hold_o(hold)
  );

  assign sys_rst_n_o  = !hold;
  assign rst_pin_oe_o = drive;
  assign ctl_q_o      = ctl_q;
  assign cause_o      = cause_q;
endmodule

// File: rtl/rstc_ctrl_chk.sv
module rstc_ctrl_chk
  import rstc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          PIN_STRETCH = 8,
  parameter int unsigned R0_LO       = 32'h0100,
  parameter int unsigned R0_HI       = 32'h01FF,
  parameter int unsigned R1_LO       = 32'h7800,
  parameter int unsigned R1_HI       = 32'h7FFF
) (
  input logic              clk,
  input logic              por_n,
  input logic              wdog_req_i,
  input logic              ctl_wr_i,
  input logic [15:0]       ctl_wdata_i,
  input logic              bus_vld_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              sys_rst_n_o,
  input logic              rst_pin_oe_o,
  input logic [15:0]       ctl_q_o,
  input logic [3:0]        cause_o
);
  logic in_rng;
  logic [7:0] oe_run;

  assign in_rng = (32'(bus_addr_i) >= R0_LO && 32'(bus_addr_i) <= R0_HI) ||
                  (32'(bus_addr_i) >= R1_LO && 32'(bus_addr_i) <= R1_HI);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            oe_run <= '0;
    else if (!rst_pin_oe_o) oe_run <= '0;
    else if (oe_run != 8'hFF) oe_run <= oe_run + 8'd1;
  end

  a_r1_wdog_fires: assert property (@(posedge clk) disable iff (!por_n)
    wdog_req_i |=> !sys_rst_n_o);

  a_r2_sw_fires: assert property (@(posedge clk) disable iff (!por_n)
    (ctl_wr_i && sys_rst_n_o && (!ctl_wdata_i[CTL_KEEP_B] || ctl_wdata_i[CTL_FIRE_B]))
    |=> !sys_rst_n_o);

  a_r3_ctl_default: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n_o |=> (ctl_q_o == CTL_RST_VAL));

  a_r4_window_fires: assert property (@(posedge clk) disable iff (!por_n)
    (bus_vld_i && sys_rst_n_o && in_rng) |=> !sys_rst_n_o);

  a_r6_min_drive: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_pin_oe_o) |-> (32'(oe_run) >= PIN_STRETCH));

  a_r6_drive_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_pin_oe_o |-> !sys_rst_n_o);

  a_r9_cause_wdog: assert property (@(posedge clk) disable iff (!por_n)
    (wdog_req_i && sys_rst_n_o) |=> cause_o[CZ_WD]);
endmodule

bind rstc_ctrl rstc_ctrl_chk #(
  .ADDR_W(ADDR_W), .PIN_STRETCH(PIN_STRETCH),
  .R0_LO(R0_LO), .R0_HI(R0_HI), .R1_LO(R1_LO), .R1_HI(R1_HI)
) u_chk (
  .clk(clk), .por_n(por_n), .wdog_req_i(wdog_req_i), .ctl_wr_i(ctl_wr_i),
  .ctl_wdata_i(ctl_wdata_i), .bus_vld_i(bus_vld_i), .bus_addr_i(bus_addr_i),
  .sys_rst_n_o(sys_rst_n_o), .rst_pin_oe_o(rst_pin_oe_o), .ctl_q_o(ctl_q_o),
  .cause_o(cause_o)
);

// File: tb/tb_rstc_ctrl.sv
`timescale 1ns/1ps
module tb_rstc_ctrl;
  localparam int AW = 8;
  localparam int unsigned W0L = 32'h20, W0H = 32'h2F, W1L = 32'hE0, W1H = 32'hFF;
  localparam int LEN_RST = 11, LEN_OE = 8;

  logic clk = 1'b0;
  logic por_n, pin_drv, wdog, wr, vld;
  logic [15:0] wdata;
  logic [AW-1:0] addr;
  logic sys_rst_n, oe, rst_pin;
  logic [15:0] ctl_q;
  logic [3:0] cause;
  int nchk = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign rst_pin = pin_drv & ~oe;

  rstc_ctrl #(.ADDR_W(AW), .R0_LO(W0L), .R0_HI(W0H), .R1_LO(W1L), .R1_HI(W1H)) dut (
    .clk(clk), .por_n(por_n), .rst_pin_i(rst_pin), .wdog_req_i(wdog),
    .ctl_wr_i(wr), .ctl_wdata_i(wdata), .bus_vld_i(vld), .bus_addr_i(addr),
    .sys_rst_n_o(sys_rst_n), .rst_pin_oe_o(oe), .ctl_q_o(ctl_q), .cause_o(cause)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && !sys_rst_n; i++) @(negedge clk);
  endtask

  // Samples win falling edges; bus strobes drop after the first,
  // the line is let go after pin_hold samples.
  task automatic observe(input int win, input int pin_hold,
                         output int first, output int last,
                         output int nrst, output int noe);
    first = 0; last = 0; nrst = 0; noe = 0;
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      if (!sys_rst_n) begin
        if (first == 0) first = k;
        last = k;
        nrst++;
      end
      if (oe) noe++;
      if (k == 1) begin wdog = 0; wr = 0; vld = 0; end
      if (k == pin_hold) pin_drv = 1;
    end
  endtask

  function automatic bit in_win(input int a);
    return (a >= W0L && a <= W0H) || (a >= W1L && a <= W1H);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    int f, l, nr, no;
    por_n = 0; pin_drv = 1; wdog = 0; wr = 0; vld = 0; wdata = '0; addr = '0;
    repeat (3) @(negedge clk);
    // R8 reset state while power-on is low
    chk(!sys_rst_n && oe, "R8 por holds", {sys_rst_n, oe}, 1);
    chk(cause == 0, "R8 cause cleared", cause, 0);
    chk(ctl_q == 16'h4000, "R3 ctl por value", ctl_q, 16'h4000);
    por_n = 1;
    observe(20, 0, f, l, nr, no);
    chk(f == 1 && l == 10 && nr == 10, "R8 por release at 11th edge", l, 10);
    chk(no == 7, "R8 line drive after por", no, 7);

    // R1/R6/R9 watchdog pulse, exact stretch, line not self-latched (R7)
    wait_idle();
    wdog = 1;
    observe(20, 0, f, l, nr, no);
    chk(f == 1 && nr == LEN_RST, "R1 R6 wdog reset length", nr, LEN_RST);
    chk(no == LEN_OE, "R6 line drive length", no, LEN_OE);
    chk(sys_rst_n, "R7 no self latch", sys_rst_n, 1);
    chk(cause == 4'b0001, "R9 cause wdog", cause, 1);

    // R2/R3 software restart sweep over the two control bits
    for (int c = 0; c < 4; c++) begin
      bit b15, b14, exp_fire;
      b15 = c[1]; b14 = c[0];
      exp_fire = !b14 || b15;
      wait_idle();
      wdata = {b15, b14, 14'h1234 ^ 14'(c * 16'h0531)};
      wr = 1;
      observe(16, 0, f, l, nr, no);
      if (exp_fire) begin
        chk(nr == LEN_RST && f == 1, "R2 sw write fires", nr, LEN_RST);
        chk(cause == 4'b0010, "R9 cause sw", cause, 2);
        chk(ctl_q == 16'h4000, "R3 ctl back to default", ctl_q, 16'h4000);
      end else begin
        chk(nr == 0, "R2 benign write no reset", nr, 0);
        chk(ctl_q == wdata, "R2 write stored", ctl_q, wdata);
      end
    end

    // R4 full address sweep
    for (int a = 0; a < 256; a++) begin
      wait_idle();
      addr = AW'(a); vld = 1;
      observe(14, 0, f, l, nr, no);
      if (in_win(a)) begin
        chk(f == 1 && nr == LEN_RST, $sformatf("R4 addr %0d fires", a), nr, LEN_RST);
        chk(cause == 4'b0100, "R9 cause window", cause, 4);
      end else
        chk(nr == 0, $sformatf("R4 addr %0d quiet", a), nr, 0);
    end
    wait_idle();
    addr = AW'(W1H); vld = 0;
    observe(14, 0, f, l, nr, no);
    chk(nr == 0, "R4 no valid no reset", nr, 0);

    // R5 line pulses of one and two clocks
    wait_idle();
    pin_drv = 0;
    observe(20, 1, f, l, nr, no);
    chk(f == 3 && nr == LEN_RST, "R5 one clock line pulse", nr, LEN_RST);
    chk(no == LEN_OE, "R6 line pulse drive", no, LEN_OE);
    chk(cause == 4'b1000, "R9 cause line", cause, 8);
    wait_idle();
    pin_drv = 0;
    observe(22, 2, f, l, nr, no);
    chk(f == 3 && nr == LEN_RST + 1 && no == LEN_OE + 1, "R5 two clock line pulse", nr, LEN_RST + 1);

    // R7 line held low for 40 clocks
    wait_idle();
    pin_drv = 0;
    observe(80, 40, f, l, nr, no);
    chk(f == 3 && nr == l - f + 1, "R7 no gap while held", nr, l - f + 1);
    chk(l >= 40 && l <= 40 + 14, "R7 released after line", l, 40);
    chk(sys_rst_n, "R7 ends after release", sys_rst_n, 1);

    // R6/R9 retrigger by watchdog during a reset
    wait_idle();
    wdata = 16'h4000; wr = 1;            // benign write first
    @(negedge clk); wr = 0;
    wdog = 1;
    nr = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (!sys_rst_n) nr++;
      if (k == 1) wdog = 0;
      if (k == 5) begin wdog = 1; wdata = 16'h8000; wr = 1; end
      if (k == 6) begin wdog = 0; wr = 0; end
    end
    chk(nr == LEN_RST + 5, "R6 retrigger restarts", nr, LEN_RST + 5);
    chk(cause == 4'b0001, "R9 retrigger keeps cause", cause, 1);

    // R10 bus and writes ignored during reset
    wait_idle();
    wdog = 1;
    nr = 0;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (!sys_rst_n) nr++;
      if (k == 1) wdog = 0;
      if (k == 5) begin vld = 1; addr = AW'(W0L); wr = 1; wdata = 16'h0000; end
      if (k == 6) begin vld = 0; wr = 0; end
      if (k == 7) begin wr = 1; wdata = 16'h5A5A; end
      if (k == 8) wr = 0;
    end
    chk(nr == LEN_RST, "R10 no extension", nr, LEN_RST);
    chk(cause == 4'b0001, "R10 cause untouched", cause, 1);
    chk(ctl_q == 16'h4000, "R3 write in reset ignored", ctl_q, 16'h4000);

    // R9 two causes together
    wait_idle();
    wdog = 1; vld = 1; addr = AW'(W1L);
    observe(14, 0, f, l, nr, no);
    chk(cause == 4'b0101, "R9 joint causes", cause, 5);

    // R8 mid-run power-on clears cause asynchronously
    wait_idle();
    por_n = 0;
    #1;
    chk(!sys_rst_n && oe && cause == 0, "R8 async por", cause, 0);
    @(negedge clk); @(negedge clk);
    por_n = 1;
    observe(20, 0, f, l, nr, no);
    chk(nr == 10 && no == 7, "R8 second release", nr, 10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule